// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects level-sensitive interrupt requests into two local groups of eight lines each and drives one CPU interrupt line per group. Each group has a status word, which is the synchronized request lines, and a mask word. A group's CPU line is high while any unmasked status bit is high. A third bank of eight shared requests, called the mapped bank, sits one level below the local groups. Each group holds its own mask over that bank. The OR of each masked view replaces one fixed status bit of that group, which is the cascade position.

For each group the block also offers an interrupt vector that names the single most urgent source. The highest-numbered pending bit wins. When the cascade position of a group is pending, its vector descends into that group's masked view of the mapped bank. Software reaches the masks, the status words and the vectors through a small register port with 4-bit addresses, 8-bit data and separate write and read strobes.

Top module: `casc_irq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, all four masks are zero, both CPU lines are low and both vectors are zero.
- R2: A group's pending set is its effective status AND its mask. The group's CPU line is high exactly when that set is nonzero.
- R3: Bit CASC0 of group 0's effective status (default 2) is the OR of (mapped status AND mapped mask 0). Bit CASC1 of group 1's effective status (default 3) is formed the same way from mapped mask 1. The external local request at a cascade position has no effect.
- R4: A nonzero masked mapped word reaches a group's CPU line and vector only when that group's local mask bit at the cascade position is set.
- R5: The vector is 5 bits: bit 4 is valid, bit 3 is the mapped flag, and bits 2:0 are the index of the highest-numbered pending bit. When nothing is pending the vector is 0.
- R6: When a group's cascade position is pending, its vector is {1, 1, index of the highest bit of that group's masked mapped word}, even if higher local bits are pending.
- R7: The two mapped masks are independent. Changing one never alters the other group's CPU line or vector.
- R8: The register addresses are: 0 group-0 effective status (read-only), 1 group-0 mask, 2 group-1 effective status (read-only), 3 group-1 mask, 4 mapped status (read-only), 5 mapped mask 0, 6 mapped mask 1, 7 vector 0 (read-only, zero-extended), 8 vector 1 (read-only, zero-extended). Any other address reads 0. Read data appears on the edge where the read strobe is sampled. A mask write takes effect on the edge where the write strobe is sampled. Writes to read-only or unused addresses are ignored.
- R9: A change on a request input reaches the status words on the third rising edge after it is applied: two synchronizer stages and one status stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc0_req | input | 8 | Group-0 asynchronous level requests |
| loc1_req | input | 8 | Group-1 asynchronous level requests |
| map_req | input | 8 | Shared mapped-bank asynchronous level requests |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| cpu_irq0 | output | 1 | Group-0 CPU interrupt line |
| cpu_irq1 | output | 1 | Group-1 CPU interrupt line |
| vec0 | output | 5 | Group-0 vector {valid, mapped, index} |
| vec1 | output | 5 | Group-1 vector {valid, mapped, index} |

## Verification
The first pattern is a single local bit under an open mask. It separates the three-stage input latency from a shorter or longer path. Several local bits under a partial mask test masking apart from priority order. A mapped request is then enabled in steps: mapped mask first, then the local cascade mask bit. These steps separate gating by the cascade mask (R4) from the descent of the vector (R6), and an external request placed on the cascade position shows that it is overridden. Opposite settings of the two mapped masks, followed by register reads of every address and writes to read-only addresses, expose cross-coupling between the groups and decode errors.

// File: rtl/casc_irq_pkg.sv
// Package: shared widths, register addresses and the vector type used by the
// cascaded interrupt controller. Assumes a power-of-two line count >= 4.
package casc_irq_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int VEC_W  = IDX_W + 2;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_STAT0 = 4'h0;
    localparam logic [ADDR_W-1:0] A_MASK0 = 4'h1;
    localparam logic [ADDR_W-1:0] A_STAT1 = 4'h2;
    localparam logic [ADDR_W-1:0] A_MASK1 = 4'h3;
    localparam logic [ADDR_W-1:0] A_MSTAT = 4'h4;
    localparam logic [ADDR_W-1:0] A_MMSK0 = 4'h5;
    localparam logic [ADDR_W-1:0] A_MMSK1 = 4'h6;
    localparam logic [ADDR_W-1:0] A_VEC0  = 4'h7;
    localparam logic [ADDR_W-1:0] A_VEC1  = 4'h8;

    typedef struct packed {
        logic             valid;
        logic             mapped;
        logic [IDX_W-1:0] idx;
    } irq_vec_t;
endpackage

// File: rtl/irq_sync.sv
// irq_sync: two-stage synchronizer for a bus of independent level requests.
// Assumes each bit is a slow level; no coherence between bits is promised.
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture the asynchronous lines, then re-time them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/prio_enc.sv
// prio_enc: fixed-priority encoder, highest-numbered set bit wins.
// Assumes W is a power of two; found is low for an all-zero input.
module prio_enc #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  in,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan upward so that the last (highest) set bit is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (in[i]) begin
                found = 1'b1;
                idx   = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/group_resolve.sv
// group_resolve: one local group. Folds the masked mapped bank into the
// cascade position, forms the pending set, the CPU line and the vector.
// Assumes CASC < W.
module group_resolve
    import casc_irq_pkg::*;
#(
    parameter int W    = 8,
    parameter int CASC = 2
) (
    input  logic [W-1:0] stat_raw,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] map_stat,
    input  logic [W-1:0] map_mask,
    output logic [W-1:0] stat_eff,
    output logic         irq,
    output irq_vec_t     vec
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  map_pend;
    logic [W-1:0]  pend;
    logic          loc_found, map_found;
    logic [IW-1:0] loc_idx, map_idx;

    assign map_pend = map_stat & map_mask;

    // Replace the external bit at the cascade slot with the mapped summary.
    always_comb begin
        stat_eff       = stat_raw;
        stat_eff[CASC] = |map_pend;
    end

    assign pend = stat_eff & mask;
    assign irq  = |pend;

    prio_enc #(.W(W)) u_loc_enc (.in(pend),     .found(loc_found), .idx(loc_idx));
    prio_enc #(.W(W)) u_map_enc (.in(map_pend), .found(map_found), .idx(map_idx));

    // Descend into the mapped bank when the cascade slot is pending.
    always_comb begin
        vec = '0;
        if (pend[CASC] && map_found) begin
            vec.valid  = 1'b1;
            vec.mapped = 1'b1;
            vec.idx    = map_idx;
        end else if (loc_found) begin
            vec.valid  = 1'b1;
            vec.idx    = loc_idx;
        end
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
// casc_irq_ctrl: two-group cascaded level interrupt controller with a
// shared mapped bank, register port and per-group vectors.
// Assumes requests are levels held until serviced; reset is synchronous.
module casc_irq_ctrl
    import casc_irq_pkg::*;
#(
    parameter int CASC0 = 2,
    parameter int CASC1 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  loc0_req,
    input  logic [LINES-1:0]  loc1_req,
    input  logic [LINES-1:0]  map_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [LINES-1:0]  reg_rdata,
    output logic              cpu_irq0,
    output logic              cpu_irq1,
    output logic [VEC_W-1:0]  vec0,
    output logic [VEC_W-1:0]  vec1
);
    localparam int NGRP = 2;
    localparam int PADW = LINES - VEC_W;

    logic [LINES-1:0] sync_l0, sync_l1, sync_m;
    logic [LINES-1:0] stat_l [NGRP];
    logic [LINES-1:0] lmask  [NGRP];
    logic [LINES-1:0] mmask  [NGRP];
    logic [LINES-1:0] stat_m;
    logic [LINES-1:0] stat_e [NGRP];
    logic             irq_g  [NGRP];
    irq_vec_t         vec_g  [NGRP];

    irq_sync #(.W(LINES)) u_sync_l0 (.clk(clk), .rst_n(rst_n), .d(loc0_req), .q(sync_l0));
    irq_sync #(.W(LINES)) u_sync_l1 (.clk(clk), .rst_n(rst_n), .d(loc1_req), .q(sync_l1));
    irq_sync #(.W(LINES)) u_sync_m  (.clk(clk), .rst_n(rst_n), .d(map_req),  .q(sync_m));

    // Status stage: sample the synchronized lines into the status words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_l[0] <= '0;
            stat_l[1] <= '0;
            stat_m    <= '0;
        end else begin
            stat_l[0] <= sync_l0;
            stat_l[1] <= sync_l1;
            stat_m    <= sync_m;
        end
    end

    // Mask registers: cleared by reset, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lmask[0] <= '0;
            lmask[1] <= '0;
            mmask[0] <= '0;
            mmask[1] <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_MASK0: lmask[0] <= reg_wdata;
                A_MASK1: lmask[1] <= reg_wdata;
                A_MMSK0: mmask[0] <= reg_wdata;
                A_MMSK1: mmask[1] <= reg_wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int CPOS = (g == 0) ? CASC0 : CASC1;
        group_resolve #(.W(LINES), .CASC(CPOS)) u_grp (
            .stat_raw (stat_l[g]),
            .mask     (lmask[g]),
            .map_stat (stat_m),
            .map_mask (mmask[g]),
            .stat_eff (stat_e[g]),
            .irq      (irq_g[g]),
            .vec      (vec_g[g])
        );
    end

    assign cpu_irq0 = irq_g[0];
    assign cpu_irq1 = irq_g[1];
    assign vec0     = vec_g[0];
    assign vec1     = vec_g[1];

    // Read port: capture the addressed word when the read strobe is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            case (reg_addr)
                A_STAT0: reg_rdata <= stat_e[0];
                A_MASK0: reg_rdata <= lmask[0];
                A_STAT1: reg_rdata <= stat_e[1];
                A_MASK1: reg_rdata <= lmask[1];
                A_MSTAT: reg_rdata <= stat_m;
                A_MMSK0: reg_rdata <= mmask[0];
                A_MMSK1: reg_rdata <= mmask[1];
                A_VEC0:  reg_rdata <= {{PADW{1'b0}}, vec_g[0]};
                A_VEC1:  reg_rdata <= {{PADW{1'b0}}, vec_g[1]};
                default: reg_rdata <= '0;
            endcase
        end
    end

    // R1
    property reset_clears_p;
        @(posedge clk) !rst_n |=> (lmask[0] == '0 && lmask[1] == '0 &&
                                   mmask[0] == '0 && mmask[1] == '0 &&
                                   !cpu_irq0 && !cpu_irq1);
    endproperty
    reset_clears_chk: assert property (reset_clears_p);

    // R2
    irq_matches_vec0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq0 == vec0[VEC_W-1]);

    // R2
    irq_matches_vec1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq1 == vec1[VEC_W-1]);

    // R4
    casc_gate0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lmask[0][CASC0] |-> !vec0[VEC_W-2]);

    // R6
    casc_descend0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask[0][CASC0] && (stat_m & mmask[0]) != '0) |-> (vec0[VEC_W-1] && vec0[VEC_W-2]));

    // R6
    casc_descend1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask[1][CASC1] && (stat_m & mmask[1]) != '0) |-> (vec1[VEC_W-1] && vec1[VEC_W-2]));

    // R8
    mask0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_MASK0) |=> lmask[0] == $past(reg_wdata));

    // R8
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_VEC0) |=> ($stable(lmask[0]) && $stable(mmask[0])));
endmodule

// File: tb/casc_irq_ctrl_bench.sv
module casc_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] loc0 = '0, loc1 = '0, mreq = '0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0, re = 1'b0;
    logic [7:0] rdata;
    logic       irq0, irq1;
    logic [4:0] v0, v1;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_irq_ctrl u_casc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .loc0_req(loc0), .loc1_req(loc1), .map_req(mreq),
        .reg_addr(addr), .reg_wdata(wdata), .reg_we(we), .reg_re(re),
        .reg_rdata(rdata), .cpu_irq0(irq0), .cpu_irq1(irq1), .vec0(v0), .vec1(v1)
    );

    // Behavioural reference model: three-deep histories and mask copies.
    logic [7:0] hl0 [3];
    logic [7:0] hl1 [3];
    logic [7:0] hm  [3];
    logic [7:0] mk0, mk1, mm0, mm1, m_rd;

    function automatic logic [2:0] top_bit(input logic [7:0] x);
        logic [2:0] r = 3'd0;
        for (int i = 0; i < 8; i++) if (x[i]) r = 3'(i);
        return r;
    endfunction

    function automatic logic [7:0] eff(input logic [7:0] loc, ms, mm, input int c);
        logic [7:0] s = loc;
        s[c] = |(ms & mm);
        return s;
    endfunction

    function automatic logic [4:0] mvec(input logic [7:0] loc, lm, ms, mm, input int c);
        logic [7:0] p = eff(loc, ms, mm, c) & lm;
        if (p[c]) return {2'b11, top_bit(ms & mm)};
        if (p != 0) return {2'b10, top_bit(p)};
        return 5'd0;
    endfunction

    function automatic logic [7:0] mread(input logic [3:0] a);
        case (a)
            4'h0: return eff(hl0[2], hm[2], mm0, 2);
            4'h1: return mk0;
            4'h2: return eff(hl1[2], hm[2], mm1, 3);
            4'h3: return mk1;
            4'h4: return hm[2];
            4'h5: return mm0;
            4'h6: return mm1;
            4'h7: return {3'b0, mvec(hl0[2], mk0, hm[2], mm0, 2)};
            4'h8: return {3'b0, mvec(hl1[2], mk1, hm[2], mm1, 3)};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin hl0[i] <= 0; hl1[i] <= 0; hm[i] <= 0; end
            mk0 <= 0; mk1 <= 0; mm0 <= 0; mm1 <= 0; m_rd <= 0;
        end else begin
            hl0[0] <= loc0; hl0[1] <= hl0[0]; hl0[2] <= hl0[1];
            hl1[0] <= loc1; hl1[1] <= hl1[0]; hl1[2] <= hl1[1];
            hm[0]  <= mreq; hm[1]  <= hm[0];  hm[2]  <= hm[1];
            if (we) begin
                if (addr == 4'h1) mk0 <= wdata;
                if (addr == 4'h3) mk1 <= wdata;
                if (addr == 4'h5) mm0 <= wdata;
                if (addr == 4'h6) mm1 <= wdata;
            end
            if (re) m_rd <= mread(addr);
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 cpu_irq0", {7'b0, irq0}, {7'b0, mvec(hl0[2], mk0, hm[2], mm0, 2) != 0});
            chk("R2 cpu_irq1", {7'b0, irq1}, {7'b0, mvec(hl1[2], mk1, hm[2], mm1, 3) != 0});
            chk("R5 vec0", {3'b0, v0}, {3'b0, mvec(hl0[2], mk0, hm[2], mm0, 2)});
            chk("R5 vec1", {3'b0, v1}, {3'b0, mvec(hl1[2], mk1, hm[2], mm1, 3)});
            chk("R8 rdata", rdata, m_rd);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        chk(req, rdata, exp);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1 irq0 in reset", {7'b0, irq0}, 8'h00);
        chk("R1 vec0 in reset", {3'b0, v0}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vec1 after reset", {3'b0, v1}, 8'h00);
        rd(4'h1, 8'h00, "R1 mask0 reset");
        rd(4'h6, 8'h00, "R1 mapmask1 reset");

        // R9: three-edge latency on a single local bit
        wr(4'h1, 8'h81);
        loc0 = 8'h01;
        @(negedge clk); @(negedge clk);
        chk("R9 not yet after two edges", {7'b0, irq0}, 8'h00);
        @(negedge clk);
        chk("R9 irq0 after three edges", {7'b0, irq0}, 8'h01);
        chk("R5 vec0 lowest bit", {3'b0, v0}, 8'h10);

        // R2/R5: masked bit 1 ignored, bit 7 wins
        loc0 = 8'h83;
        settle();
        chk("R5 vec0 highest bit", {3'b0, v0}, 8'h17);
        loc0 = 8'h02;
        settle();
        chk("R2 masked bit gives no irq", {7'b0, irq0}, 8'h00);
        loc0 = 8'h83;

        // R4: mapped mask set but cascade mask bit clear
        mreq = 8'h24;
        settle();
        wr(4'h5, 8'h04);
        chk("R4 cascade gated by local mask", {3'b0, v0}, 8'h17);

        // R6: cascade pending descends even with bit 7 pending
        wr(4'h1, 8'h85);
        chk("R6 vec0 descends", {3'b0, v0}, 8'h1A);
        wr(4'h5, 8'hFF);
        chk("R6 highest mapped bit", {3'b0, v0}, 8'h1D);

        // R3: external line at cascade slot is overridden
        loc0 = 8'h04;
        wr(4'h5, 8'h00);
        settle();
        chk("R3 external cascade line ignored", {7'b0, irq0}, 8'h00);
        rd(4'h0, 8'h00, "R3 istat0 cascade slot from mapped bank");

        // R7: independent mapped masks
        wr(4'h3, 8'h08);
        wr(4'h6, 8'h20);
        chk("R7 vec1 via mapped mask1", {3'b0, v1}, 8'h1D);
        chk("R7 group0 untouched", {7'b0, irq0}, 8'h00);
        wr(4'h5, 8'h20);
        chk("R7 vec0 via mapped mask0", {3'b0, v0}, 8'h1D);
        wr(4'h6, 8'h00);
        chk("R7 vec1 cleared", {3'b0, v1}, 8'h00);
        chk("R7 vec0 kept", {3'b0, v0}, 8'h1D);

        // R8: register map, read-only and unused addresses
        wr(4'h0, 8'hFF);
        wr(4'h7, 8'hFF);
        rd(4'h0, 8'h04, "R8 istat0 write ignored");
        rd(4'h1, 8'h85, "R8 mask0 readback");
        rd(4'h4, 8'h24, "R8 mapped status");
        rd(4'h7, 8'h1D, "R8 vector0 read");
        rd(4'h8, 8'h00, "R8 vector1 read");
        rd(4'h9, 8'h00, "R8 unused address");
        loc1 = 8'h40;
        settle();
        rd(4'h2, 8'h40, "R8 istat1 read");
        chk("R5 vec1 local", {3'b0, v1}, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule